// File: doc/BRIEF.md
# Arbitrary-Modulus Phase Accumulator

This block is the phase engine of a direct digital synthesizer whose accumulator wraps at a programmable integer modulus rather than at a power of two. On every reference clock it adds a programmable step to its phase. When the sum reaches or passes the modulus, the modulus is subtracted from it. The result is an output rate of exactly Fin * step / modulus for any integer pair. Decimal moduli such as 10000 and odd frequency-plan denominators such as 757 are therefore produced with no rounding error.

A load strobe captures a new step and modulus together and clears the phase in the same edge. A load whose step is zero, or whose step is not strictly below the modulus, is refused. In that case the running settings are kept and a one-cycle error pulse is raised. The outputs are the phase word, a one-cycle wrap pulse that marks each output period, and a square wave that is high for the upper half of the phase range. Sine lookup, conversion to analog and any later frequency multiplication belong to other blocks.

Top module: `modphase_synth`

## Requirements
- R1: The phase output is always strictly below the active modulus.
- R2: When no load is applied, each clock sets the phase to phase+step if that sum is below the modulus, and to phase+step-modulus otherwise.
- R3: The wrap pulse is high for exactly the cycles whose phase was produced by subtracting the modulus. Over the Q clocks that follow an accepted load, exactly P wrap pulses occur.
- R4: With modulus 10000 and step 1, wrap pulses are exactly 10000 clocks apart.
- R5: With modulus 757 and step 14, every window of 757 clocks after the load holds exactly 14 wrap pulses.
- R6: An accepted load (step nonzero and step < modulus) clears the phase and the wrap pulse on the following clock. The new settings are used from that cycle on.
- R7: A load with step 0 is refused. The error output is 1 for exactly the cycle after the strobe, and the phase keeps advancing with the old settings.
- R8: A load with step equal to or greater than the modulus is refused in the same way as in R7.
- R9: The square output is 1 exactly when the phase is at least floor(modulus/2).
- R10: After synchronous reset the step is 0 and the modulus is RST_MOD (default 2). The phase therefore holds at 0, and the wrap, error and square outputs are all 0.
- R11: The wrap decision is made on a sum one bit wider than the phase. With modulus 0xFFFFFFFF and step 0xFFFFFFFE, 19 of the first 20 clocks wrap.
- R12: A binary modulus of 2^20 with step 105 cannot give a period of exactly 10000 clocks. After 10000 clocks the phase is 1424 and only 1 wrap has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe that captures step_in and mod_in |
| step_in | input | ACC_W | Requested phase step P |
| mod_in | input | ACC_W | Requested modulus Q |
| phase_out | output | ACC_W | Current phase, always below Q |
| wrap_pulse | output | 1 | High for one cycle on each modulus wrap |
| square_out | output | 1 | High while phase >= floor(Q/2) |
| load_err | output | 1 | One-cycle flag for a refused load |

## Verification
The bench goes after the wrap decision at its edges: a sum equal to the modulus, and sums that carry out of 32 bits. A design that compared with a strict greater-than, or that dropped the carry bit, would drift off the exact pulse counts or would leave the phase above the modulus. Refused loads with step 0, step equal to Q and step above Q are all exercised. A design that half-applied such a load would clear the phase or switch rates when it should not. The 2^20 case is the contrast with the exact decimal case. A correct design must show a residual phase of 1424 there.

// File: rtl/modphase_pkg.sv
package modphase_pkg;

   typedef enum logic [1:0] {
      CFG_HOLD   = 2'd0,
      CFG_TAKE   = 2'd1,
      CFG_REFUSE = 2'd2
   } cfg_act_e;

endpackage

// File: rtl/modphase_cfg.sv
module modphase_cfg
   import modphase_pkg::*;
#(
   parameter int ACC_W   = 32,
   parameter int RST_MOD = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [ACC_W-1:0] step_in,
   input  logic [ACC_W-1:0] mod_in,
   output logic [ACC_W-1:0] step_q,
   output logic [ACC_W-1:0] mod_q,
   output logic             apply,
   output logic             err_q
);

   localparam logic [ACC_W-1:0] RST_MOD_W = ACC_W'(RST_MOD);

   cfg_act_e act;

   always_comb begin
      if (!load)
         act = CFG_HOLD;
      else if (step_in == '0 || step_in >= mod_in)
         act = CFG_REFUSE;
      else
         act = CFG_TAKE;
   end

   assign apply = (act == CFG_TAKE);

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= '0;
         mod_q  <= RST_MOD_W;
         err_q  <= 1'b0;
      end else begin
         err_q <= (act == CFG_REFUSE);
         if (act == CFG_TAKE) begin
            step_q <= step_in;
            mod_q  <= mod_in;
         end
      end
   end

   // R7 / R8: a refused load leaves the settings untouched and flags it.
   assert_refuse_keeps_R8: assert property (@(posedge clk) disable iff (rst)
      (load && (step_in == '0 || step_in >= mod_in))
      |=> (err_q && $stable(step_q) && $stable(mod_q)));

   // R6: an accepted load installs the requested pair.
   assert_take_installs_R6: assert property (@(posedge clk) disable iff (rst)
      (load && step_in != '0 && step_in < mod_in)
      |=> (!err_q && step_q == $past(step_in) && mod_q == $past(mod_in)));

   // R1 support: installed step is always below the modulus.
   assert_cfg_valid_R1: assert property (@(posedge clk) disable iff (rst)
      step_q < mod_q);

endmodule

// File: rtl/modphase_accum.sv
module modphase_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             apply,
   input  logic [ACC_W-1:0] step,
   input  logic [ACC_W-1:0] modulus,
   output logic [ACC_W-1:0] phase,
   output logic             wrap
);

   localparam int EXT_W = ACC_W + 1;

   logic [EXT_W-1:0] sum_ext;
   logic [EXT_W-1:0] red_ext;
   logic             over;

   assign sum_ext = {1'b0, phase} + {1'b0, step};
   assign red_ext = sum_ext - {1'b0, modulus};
   assign over    = (sum_ext >= {1'b0, modulus});

   always_ff @(posedge clk) begin
      if (rst || apply) begin
         phase <= '0;
         wrap  <= 1'b0;
      end else begin
         phase <= over ? red_ext[ACC_W-1:0] : sum_ext[ACC_W-1:0];
         wrap  <= over;
      end
   end

   assert_phase_below_mod_R1: assert property (@(posedge clk) disable iff (rst)
      phase < modulus);

   // R2: the new phase plus any subtracted modulus equals old phase plus step.
   assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
      (!apply)
      |=> (({1'b0, phase} + (wrap ? {1'b0, $past(modulus)} : {EXT_W{1'b0}}))
           == ({1'b0, $past(phase)} + {1'b0, $past(step)})));

   // R3: a wrapped phase always lands below the step that produced it.
   assert_wrap_lands_low_R3: assert property (@(posedge clk) disable iff (rst)
      wrap |-> (phase < step));

   // R6: an accepted load clears the phase and the pulse.
   assert_apply_clears_R6: assert property (@(posedge clk) disable iff (rst)
      apply |=> (phase == '0 && !wrap));

endmodule

// File: rtl/modphase_square.sv
module modphase_square #(
   parameter int ACC_W  = 32,
   parameter bit SQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] phase,
   input  logic [ACC_W-1:0] modulus,
   output logic             square
);

   logic [ACC_W-1:0] half;
   logic             upper;

   assign half  = modulus >> 1;
   assign upper = (phase >= half);

   generate
      if (SQ_REG) begin : g_reg
         logic sq_q;
         always_ff @(posedge clk) begin
            if (rst) sq_q <= 1'b0;
            else     sq_q <= upper;
         end
         assign square = sq_q;
      end else begin : g_comb
         assign square = upper;
         // R9: modulus is at least 2, so a zero phase is in the lower half.
         assert_square_low_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
            (phase == '0) |-> !square);
      end
   endgenerate

endmodule

// File: rtl/modphase_synth.sv
module modphase_synth #(
   parameter int ACC_W   = 32,
   parameter int RST_MOD = 2,
   parameter bit SQ_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [ACC_W-1:0] step_in,
   input  logic [ACC_W-1:0] mod_in,
   output logic [ACC_W-1:0] phase_out,
   output logic             wrap_pulse,
   output logic             square_out,
   output logic             load_err
);

   generate
      if (ACC_W < 2 || ACC_W > 62) begin : g_bad_width
         $error("modphase_synth: ACC_W out of range");
      end
      if (RST_MOD < 2) begin : g_bad_rst_mod
         $error("modphase_synth: RST_MOD must be at least 2");
      end
      if (ACC_W < 31 && RST_MOD >= (1 << ACC_W)) begin : g_rst_mod_wide
         $error("modphase_synth: RST_MOD does not fit ACC_W");
      end
   endgenerate

   logic [ACC_W-1:0] step_q;
   logic [ACC_W-1:0] mod_q;
   logic             apply;

   modphase_cfg #(
      .ACC_W  (ACC_W),
      .RST_MOD(RST_MOD)
   ) u_cfg (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .step_in(step_in),
      .mod_in (mod_in),
      .step_q (step_q),
      .mod_q  (mod_q),
      .apply  (apply),
      .err_q  (load_err)
   );

   modphase_accum #(
      .ACC_W(ACC_W)
   ) u_accum (
      .clk    (clk),
      .rst    (rst),
      .apply  (apply),
      .step   (step_q),
      .modulus(mod_q),
      .phase  (phase_out),
      .wrap   (wrap_pulse)
   );

   modphase_square #(
      .ACC_W (ACC_W),
      .SQ_REG(SQ_REG)
   ) u_square (
      .clk    (clk),
      .rst    (rst),
      .phase  (phase_out),
      .modulus(mod_q),
      .square (square_out)
   );

   // R7: the error flag never lasts longer than one cycle without a new strobe.
   assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      (load_err && !$past(load)) |-> 1'b0);

endmodule

// File: tb/modphase_synth_test.sv
module modphase_synth_test;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic [W-1:0] step_in = '0;
   logic [W-1:0] mod_in = '0;
   logic [W-1:0] phase_out;
   logic         wrap_pulse, square_out, load_err;

   int checks = 0;
   int errors = 0;
   int cycle  = 0;

   always #4 clk = ~clk;

   modphase_synth uut (
      .clk(clk), .rst(rst), .load(load), .step_in(step_in), .mod_in(mod_in),
      .phase_out(phase_out), .wrap_pulse(wrap_pulse),
      .square_out(square_out), .load_err(load_err)
   );

   // Behavioural reference model
   longint unsigned m_p = 0, m_q = 2, m_ph = 0;
   bit m_w = 0, m_e = 0;

   always @(posedge clk) begin
      cycle++;
      if (rst) begin
         m_p = 0; m_q = 2; m_ph = 0; m_w = 0; m_e = 0;
      end else if (load && step_in != 0 && step_in < mod_in) begin
         m_p = step_in; m_q = mod_in; m_ph = 0; m_w = 0; m_e = 0;
      end else begin
         m_e = load;
         m_ph = m_ph + m_p;
         m_w = (m_ph >= m_q);
         if (m_w) m_ph = m_ph - m_q;
      end
   end

   task automatic check(input bit ok, input string req, input longint unsigned act,
                        input longint unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model (away from the active edge)
   always @(negedge clk) begin
      if (!rst) begin
         check(phase_out == m_ph[W-1:0], "R2 phase", phase_out, m_ph);
         check(wrap_pulse == m_w, "R3 wrap", wrap_pulse, m_w);
         check(load_err == m_e, "R7 err", load_err, m_e);
         check(square_out == (m_ph >= (m_q >> 1)), "R9 square", square_out,
               (m_ph >= (m_q >> 1)));
         check(phase_out < m_q, "R1 below modulus", phase_out, m_q);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic do_load(input longint unsigned p, input longint unsigned q);
      step_in = W'(p); mod_in = W'(q); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic count_wraps(input int n, output int wraps, output int last_gap);
      int since = 0;
      wraps = 0; last_gap = -1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         since++;
         if (wrap_pulse) begin
            wraps++;
            last_gap = since;
            since = 0;
         end
      end
   endtask

   initial begin
      int wr, gap;
      longint unsigned ph_keep;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10: reset state
      check(phase_out == 0 && !wrap_pulse && !load_err && !square_out,
            "R10 reset state", phase_out, 0);
      repeat (4) @(negedge clk);
      check(phase_out == 0, "R10 phase holds", phase_out, 0);

      // R4: exact decimal 1 kHz from 10 MHz
      do_load(1, 10000);
      check(phase_out == 0 && !wrap_pulse, "R6 load clears", phase_out, 0);
      count_wraps(10000, wr, gap);
      check(wr == 1, "R4 pulses per 10000", wr, 1);
      count_wraps(10000, wr, gap);
      check(gap == 10000, "R4 spacing", gap, 10000);

      // R5: odd denominator
      do_load(14, 757);
      for (int k = 0; k < 3; k++) begin
         count_wraps(757, wr, gap);
         check(wr == 14, "R5 14 per 757", wr, 14);
      end

      // R3: several pairs, including power-of-two modulus
      do_load(3, 7);    count_wraps(7, wr, gap);    check(wr == 3, "R3 3/7", wr, 3);
      do_load(5, 8);    count_wraps(8, wr, gap);    check(wr == 5, "R3 5/8", wr, 5);
      do_load(999, 1000); count_wraps(1000, wr, gap); check(wr == 999, "R3 999/1000", wr, 999);

      // R9: 7/10 sequence, phase 7 is upper half
      do_load(7, 10);
      @(negedge clk);
      check(phase_out == 7 && square_out, "R9 phase 7 high", square_out, 1);
      @(negedge clk);
      check(phase_out == 4 && !square_out && wrap_pulse, "R9 phase 4 low", square_out, 0);
      count_wraps(8, wr, gap);

      // R7: step 0 refused
      ph_keep = phase_out;
      do_load(0, 100);
      check(load_err, "R7 err raised", load_err, 1);
      check(phase_out == (ph_keep + 7) % 10, "R7 phase keeps running", phase_out,
            (ph_keep + 7) % 10);
      @(negedge clk);
      check(!load_err, "R7 err one cycle", load_err, 0);
      count_wraps(10, wr, gap);
      check(wr == 7, "R7 old rate kept", wr, 7);

      // R8: step equal to and above modulus refused
      do_load(50, 50);
      check(load_err, "R8 equal refused", load_err, 1);
      do_load(60, 50);
      check(load_err, "R8 above refused", load_err, 1);
      count_wraps(10, wr, gap);
      check(wr == 7, "R8 old rate kept", wr, 7);

      // R11: carry bit on wide values
      do_load(64'hFFFF_FFFE, 64'hFFFF_FFFF);
      count_wraps(20, wr, gap);
      check(wr == 19, "R11 wide wraps", wr, 19);

      // R12: binary modulus cannot hit a 10000-clock period
      do_load(105, 1 << 20);
      count_wraps(10000, wr, gap);
      check(wr == 1, "R12 one wrap", wr, 1);
      check(phase_out == 1424, "R12 residual phase", phase_out, 1424);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule